// File: doc/BRIEF.md
# Phase-Shift Full-Bridge PWM Generator

This block turns two digital timing events into the four gate-drive commands of a full bridge. The bridge has two legs. The first leg (outputs A and B) changes state on every oscillator clock pulse, so it runs at half the oscillator rate with about 50% duty. The second leg (outputs C and D) changes state on a PWM trip, which is the digital form of the ramp crossing the error level. The phase offset between the two legs, and not the width of any single pulse, sets the power delivered. That offset can reach any value from zero to a full period.

Inside each leg the two outputs are complementary. Each time a leg changes state, the output that is switching off drops at once. The output that is switching on waits for a programmable number of clock cycles of dead time. Each leg has its own dead-time value and its own bypass input, which forces that leg's dead time to zero. Deasserting the enable input forces all four outputs low together and clears the sequencing state. After enable returns, the first clock pulse restarts both legs with A and C as the high sides.

The oscillator, the comparators and the gate drivers are outside the block. They appear here only as single-cycle event inputs and registered drive outputs.

Top module: `psfb_pwm_gen`

## Requirements
- R1: After reset, and while enabled but before the first oscillator pulse, all four outputs are low.
- R2: Each oscillator pulse sampled while enabled toggles the A/B leg once. The high side is A after an odd number of pulses since enable and B after an even number.
- R3: A and B are never high in the same cycle, and neither are C and D.
- R4: A leg change sampled at clock edge t drives both outputs of that leg low from edge t. The on-going output rises at edge t+D, where D is the dead-time value sampled with the change. Both outputs therefore stay low for exactly D cycles.
- R5: With a leg's bypass input high, or with D equal to 0, the change swaps the two outputs at edge t with no cycle in which both are low.
- R6: The A/B leg uses dead_ab and bypass_ab. The C/D leg uses dead_cd and bypass_cd. Each leg ignores the other leg's values.
- R7: Each oscillator pulse after the first one since enable arms the C/D leg. The first PWM trip seen while armed toggles the C/D leg and disarms it.
- R8: The C/D leg toggles at most once per oscillator period. A trip seen while disarmed has no effect on C or D.
- R9: While enable is low, all four outputs are low from the next clock edge. Oscillator pulses and trips have no effect during that time.
- R10: After enable is reasserted, trips before the first oscillator pulse are ignored. That first pulse starts both legs, with A and C as the high sides.
- R11: A trip that arrives in the same cycle as an oscillator pulse, while the C/D leg is armed, toggles the C/D leg in that cycle and re-arms it for the new period (full phase shift).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Output enable; low forces all outputs off |
| osc_pulse | input | 1 | One-cycle oscillator clock event |
| pwm_trip | input | 1 | One-cycle PWM comparator trip event |
| dead_ab | input | DT_W | Dead time of the A/B leg in clock cycles |
| dead_cd | input | DT_W | Dead time of the C/D leg in clock cycles |
| bypass_ab | input | 1 | Forces zero dead time on the A/B leg |
| bypass_cd | input | 1 | Forces zero dead time on the C/D leg |
| out_a | output | 1 | High-side command, leg A/B |
| out_b | output | 1 | Low-side command, leg A/B |
| out_c | output | 1 | High-side command, leg C/D |
| out_d | output | 1 | Low-side command, leg C/D |

## Verification
All four outputs are registered. An event or a disable that is sampled at edge t is visible just after edge t: the off-going output drops then, or, with a zero or bypassed dead time, the outputs swap then. The on-going output with dead time D appears just after edge t+D. The bench drives inputs one time unit after an edge, advances its cycle model for that edge, and compares one time unit after the next edge. The directed checks count edges from the triggering pulse to those exact cycles.

// File: rtl/psfb_pkg.sv
package psfb_pkg;

  localparam int DEAD_W_MAX = 16;

  typedef logic [DEAD_W_MAX-1:0] dead_t;

  typedef enum logic {
    LEG_AB = 1'b0,
    LEG_CD = 1'b1
  } leg_e;

  // Dead time actually applied on a leg change.
  function automatic dead_t eff_dead(input dead_t req, input logic skip);
    return skip ? '0 : req;
  endfunction

  // True in the cycle whose edge releases the on-going output.
  function automatic logic turn_on_due(input dead_t left);
    return left == dead_t'(1);
  endfunction

endpackage

// File: rtl/psfb_evt_ctrl.sv
module psfb_evt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic osc_pulse,
  input  logic pwm_trip,
  output logic ab_toggle,
  output logic cd_toggle
);

  logic started_q;
  logic armed_q;
  logic start_evt;
  logic trip_take;

  assign start_evt = enable & osc_pulse & ~started_q;
  assign trip_take = enable & armed_q & pwm_trip;
  assign ab_toggle = enable & osc_pulse;
  assign cd_toggle = start_evt | trip_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      armed_q   <= 1'b0;
    end else if (!enable) begin
      started_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      if (osc_pulse) begin
        started_q <= 1'b1;
      end
      if (osc_pulse && started_q) begin
        armed_q <= 1'b1;
      end else if (trip_take) begin
        armed_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/psfb_leg.sv
module psfb_leg #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            toggle,
  input  logic [DT_W-1:0] dead_cyc,
  input  logic            bypass,
  output logic            drv_hi,
  output logic            drv_lo,
  output logic            busy
);

  logic            ph_q;
  logic [DT_W-1:0] cnt_q;
  logic            hi_q;
  logic            lo_q;
  logic [DT_W-1:0] load;

  assign load = DT_W'(psfb_pkg::eff_dead(psfb_pkg::dead_t'(dead_cyc), bypass));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else if (!enable) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
      hi_q  <= 1'b0;
      lo_q  <= 1'b0;
    end else if (toggle) begin
      ph_q <= ~ph_q;
      if (load == '0) begin
        cnt_q <= '0;
        hi_q  <= ~ph_q;
        lo_q  <= ph_q;
      end else begin
        cnt_q <= load;
        hi_q  <= 1'b0;
        lo_q  <= 1'b0;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (psfb_pkg::turn_on_due(psfb_pkg::dead_t'(cnt_q))) begin
        hi_q <= ph_q;
        lo_q <= ~ph_q;
      end
    end
  end

  assign drv_hi = hi_q;
  assign drv_lo = lo_q;
  assign busy   = cnt_q != '0;

endmodule

// File: rtl/psfb_pwm_gen.sv
module psfb_pwm_gen #(
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            osc_pulse,
  input  logic            pwm_trip,
  input  logic [DT_W-1:0] dead_ab,
  input  logic [DT_W-1:0] dead_cd,
  input  logic            bypass_ab,
  input  logic            bypass_cd,
  output logic            out_a,
  output logic            out_b,
  output logic            out_c,
  output logic            out_d
);

  localparam int NLEG = 2;

  logic            ab_toggle;
  logic            cd_toggle;
  logic            ab_busy;
  logic            cd_busy;
  logic [NLEG-1:0] leg_tgl;
  logic [NLEG-1:0] leg_byp;
  logic [NLEG-1:0] leg_hi;
  logic [NLEG-1:0] leg_lo;
  logic [NLEG-1:0] leg_busy;
  logic [DT_W-1:0] leg_dt [NLEG];

  psfb_evt_ctrl u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .osc_pulse (osc_pulse),
    .pwm_trip  (pwm_trip),
    .ab_toggle (ab_toggle),
    .cd_toggle (cd_toggle)
  );

  assign leg_tgl[psfb_pkg::LEG_AB] = ab_toggle;
  assign leg_tgl[psfb_pkg::LEG_CD] = cd_toggle;
  assign leg_byp[psfb_pkg::LEG_AB] = bypass_ab;
  assign leg_byp[psfb_pkg::LEG_CD] = bypass_cd;
  assign leg_dt[psfb_pkg::LEG_AB]  = dead_ab;
  assign leg_dt[psfb_pkg::LEG_CD]  = dead_cd;

  generate
    for (genvar g = 0; g < NLEG; g++) begin : g_leg
      psfb_leg #(.DT_W(DT_W)) u_leg (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .toggle   (leg_tgl[g]),
        .dead_cyc (leg_dt[g]),
        .bypass   (leg_byp[g]),
        .drv_hi   (leg_hi[g]),
        .drv_lo   (leg_lo[g]),
        .busy     (leg_busy[g])
      );
    end
  endgenerate

  assign out_a   = leg_hi[psfb_pkg::LEG_AB];
  assign out_b   = leg_lo[psfb_pkg::LEG_AB];
  assign out_c   = leg_hi[psfb_pkg::LEG_CD];
  assign out_d   = leg_lo[psfb_pkg::LEG_CD];
  assign ab_busy = leg_busy[psfb_pkg::LEG_AB];
  assign cd_busy = leg_busy[psfb_pkg::LEG_CD];

endmodule

// File: rtl/psfb_pwm_gen_chk.sv
module psfb_pwm_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic out_a,
  input logic out_b,
  input logic out_c,
  input logic out_d,
  input logic ab_toggle,
  input logic cd_toggle,
  input logic ab_busy,
  input logic cd_busy
);

  logic [1:0] cd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cd_cnt <= '0;
    end else if (ab_toggle || !enable) begin
      cd_cnt <= '0;
    end else if (cd_toggle && cd_cnt != 2'd3) begin
      cd_cnt <= cd_cnt + 2'd1;
    end
  end

  AST_AB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b)); // R3
  AST_CD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_c && out_d)); // R3
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(out_a || out_b || out_c || out_d)); // R9
  AST_AB_DEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ab_busy |-> (!out_a && !out_b)); // R4
  AST_CD_DEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cd_busy |-> (!out_c && !out_d)); // R4
  AST_AB_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_a) || $rose(out_b)) |-> ($past(ab_toggle) || $past(ab_busy))); // R2
  AST_CD_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_c) || $rose(out_d)) |-> ($past(cd_toggle) || $past(cd_busy))); // R7
  AST_CD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_toggle && !ab_toggle) |-> (cd_cnt == 2'd0)); // R8

endmodule

bind psfb_pwm_gen psfb_pwm_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .out_a     (out_a),
  .out_b     (out_b),
  .out_c     (out_c),
  .out_d     (out_d),
  .ab_toggle (ab_toggle),
  .cd_toggle (cd_toggle),
  .ab_busy   (ab_busy),
  .cd_busy   (cd_busy)
);

// File: tb/psfb_pwm_gen_tb.sv
`timescale 1ns/1ps
module psfb_pwm_gen_tb;

  localparam int DT_W = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            enable = 1'b0;
  logic            osc_pulse = 1'b0;
  logic            pwm_trip = 1'b0;
  logic [DT_W-1:0] dead_ab = '0;
  logic [DT_W-1:0] dead_cd = '0;
  logic            bypass_ab = 1'b0;
  logic            bypass_cd = 1'b0;
  logic            out_a, out_b, out_c, out_d;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;
  string tag_ab = "R2";
  string tag_cd = "R7";

  // cycle model built from the requirements
  bit m_st, m_arm;
  bit m_ph [2];
  int m_rem [2];
  bit m_hi [2];
  bit m_lo [2];

  always #2 clk = ~clk;

  psfb_pwm_gen #(.DT_W(DT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .osc_pulse(osc_pulse),
    .pwm_trip(pwm_trip), .dead_ab(dead_ab), .dead_cd(dead_cd),
    .bypass_ab(bypass_ab), .bypass_cd(bypass_cd),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic void model_clear();
    m_st = 0; m_arm = 0;
    for (int k = 0; k < 2; k++) begin
      m_ph[k] = 0; m_rem[k] = 0; m_hi[k] = 0; m_lo[k] = 0;
    end
  endfunction

  function automatic void model_step();
    bit ev [2];
    int d [2];
    if (!enable) begin
      model_clear();
      return;
    end
    ev[0] = osc_pulse;
    ev[1] = (osc_pulse && !m_st) || (m_arm && pwm_trip);
    d[0] = bypass_ab ? 0 : int'(dead_ab);
    d[1] = bypass_cd ? 0 : int'(dead_cd);
    if (osc_pulse && m_st) m_arm = 1;
    else if (m_arm && pwm_trip) m_arm = 0;
    if (osc_pulse) m_st = 1;
    for (int k = 0; k < 2; k++) begin
      if (ev[k]) begin
        m_ph[k] = !m_ph[k];
        if (d[k] == 0) begin
          m_rem[k] = 0; m_hi[k] = m_ph[k]; m_lo[k] = !m_ph[k];
        end else begin
          m_rem[k] = d[k]; m_hi[k] = 0; m_lo[k] = 0;
        end
      end else if (m_rem[k] > 0) begin
        m_rem[k]--;
        if (m_rem[k] == 0) begin
          m_hi[k] = m_ph[k]; m_lo[k] = !m_ph[k];
        end
      end
    end
  endfunction

  task automatic tick();
    model_step();
    @(posedge clk);
    #1;
    chk(out_a === m_hi[0] && out_b === m_lo[0], tag_ab,
        int'({out_a, out_b}), int'({m_hi[0], m_lo[0]}));
    chk(out_c === m_hi[1] && out_d === m_lo[1], tag_cd,
        int'({out_c, out_d}), int'({m_hi[1], m_lo[1]}));
    chk(!(out_a && out_b) && !(out_c && out_d), "R3",
        int'({out_a, out_b, out_c, out_d}), 0);
  endtask

  task automatic run_period(input int len, input int trip_at);
    for (int i = 0; i < len; i++) begin
      osc_pulse = (i == 0);
      pwm_trip  = (i == trip_at);
      tick();
    end
    osc_pulse = 0;
    pwm_trip  = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: act=%0d exp=0 cycles left", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit pa, c0, c1;
    int per, left, dis;
    void'($urandom(32'd20240611));
    model_clear();

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk({out_a, out_b, out_c, out_d} == 4'b0000, "R1", int'({out_a, out_b, out_c, out_d}), 0);
    rst_n = 1; enable = 1;
    tag_ab = "R1"; tag_cd = "R1";
    repeat (3) tick();

    // R4 / R6 / R10: first pulse with different dead times per leg
    dead_ab = 6'd3; dead_cd = 6'd2;
    osc_pulse = 1; tick(); osc_pulse = 0;
    chk({out_a, out_b} == 2'b00, "R4", int'({out_a, out_b}), 0);
    chk({out_c, out_d} == 2'b00, "R4", int'({out_c, out_d}), 0);
    tick();
    chk({out_a, out_b, out_c, out_d} == 4'b0000, "R4", int'({out_a, out_b, out_c, out_d}), 0);
    tick();
    chk({out_c, out_d} == 2'b10, "R6", int'({out_c, out_d}), 2);
    chk({out_a, out_b} == 2'b00, "R6", int'({out_a, out_b}), 0);
    tick();
    chk({out_a, out_b} == 2'b10, "R4", int'({out_a, out_b}), 2);

    // R2 / R7: steady phase-shifted operation
    tag_ab = "R2"; tag_cd = "R7";
    for (int p = 0; p < 4; p++) run_period(16, 6);

    // R5: bypass swaps immediately
    bypass_ab = 1; bypass_cd = 1;
    tag_ab = "R5"; tag_cd = "R5";
    pa = out_a;
    osc_pulse = 1; tick(); osc_pulse = 0;
    chk(out_a == !pa && out_b == pa, "R5", int'({out_a, out_b}), int'({!pa, pa}));
    repeat (4) tick();

    // R8: second trip in one period is ignored
    tag_cd = "R8";
    osc_pulse = 1; tick(); osc_pulse = 0;
    tick(); tick();
    c0 = out_c;
    pwm_trip = 1; tick(); pwm_trip = 0;
    chk(out_c == !c0, "R7", int'(out_c), int'(!c0));
    tick();
    pwm_trip = 1; tick(); pwm_trip = 0;
    chk(out_c == !c0, "R8", int'(out_c), int'(!c0));
    tick();

    // R11: trip together with pulse while armed
    tag_cd = "R11";
    osc_pulse = 1; tick(); osc_pulse = 0;
    c1 = out_c;
    tick();
    osc_pulse = 1; pwm_trip = 1; tick(); osc_pulse = 0; pwm_trip = 0;
    chk(out_c == !c1, "R11", int'(out_c), int'(!c1));
    tick();
    pwm_trip = 1; tick(); pwm_trip = 0;
    chk(out_c == c1, "R11", int'(out_c), int'(c1));

    // R9: disable during dead time, events ignored while off
    tag_ab = "R9"; tag_cd = "R9";
    bypass_ab = 0; dead_ab = 6'd5;
    osc_pulse = 1; tick(); osc_pulse = 0;
    enable = 0; tick();
    chk({out_a, out_b, out_c, out_d} == 4'b0000, "R9", int'({out_a, out_b, out_c, out_d}), 0);
    for (int i = 0; i < 5; i++) begin
      osc_pulse = i[0]; pwm_trip = !i[0];
      tick();
      chk({out_a, out_b, out_c, out_d} == 4'b0000, "R9", int'({out_a, out_b, out_c, out_d}), 0);
    end
    osc_pulse = 0; pwm_trip = 0;

    // R10: restart after re-enable
    tag_ab = "R10"; tag_cd = "R10";
    enable = 1; bypass_ab = 1; bypass_cd = 1;
    pwm_trip = 1; tick(); pwm_trip = 0;
    chk({out_a, out_b, out_c, out_d} == 4'b0000, "R10", int'({out_a, out_b, out_c, out_d}), 0);
    osc_pulse = 1; tick(); osc_pulse = 0;
    chk({out_a, out_b, out_c, out_d} == 4'b1010, "R10", int'({out_a, out_b, out_c, out_d}), 10);

    // random mix, R2 / R6 / R7 against the model
    tag_ab = "R2"; tag_cd = "R6";
    left = 0; dis = 0;
    for (int i = 0; i < 5000; i++) begin
      if (left == 0) begin
        per = 6 + int'($urandom_range(18));
        left = per;
        dead_ab = DT_W'($urandom_range(7));
        dead_cd = DT_W'($urandom_range(7));
        bypass_ab = ($urandom_range(5) == 0);
        bypass_cd = ($urandom_range(5) == 0);
      end
      osc_pulse = (left == per);
      pwm_trip  = ($urandom_range(7) == 0);
      left--;
      if (dis > 0) begin
        dis--;
        enable = (dis == 0);
      end else if ($urandom_range(299) == 0) begin
        enable = 0;
        dis = 1 + int'($urandom_range(4));
      end
      tick();
    end
    osc_pulse = 0; pwm_trip = 0; enable = 1;
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule